// File: doc/BRIEF.md
# Packed Nibble Weight Dot Product Engine

This block produces the integer dot product of a vector of unsigned 4-bit weights with a vector of signed 8-bit activations. The weights stay packed two to a byte and are never widened into full-size values in storage. The vector arrives as a stream of beats. Each beat carries 32 weight bytes holding 64 weights, which make two 32-element sub-blocks. With them come the 64 matching activations, a scale field and a minimum field for each of the two sub-blocks, and one precomputed activation sum per sub-block. Four beats form one 256-element super-block. A vector is made of whole super-blocks.

For each sub-block, sixteen lanes multiply nibbles by activations. Each lane adds the products from the two 16-element halves of the sub-block, and the lane results are reduced to an exact sub-block sum. That sum is multiplied by the sub-block's 4-bit scale. The sub-block's 4-bit minimum is multiplied by its supplied activation sum, and this product is subtracted, so the weight offset is removed without adjusting any weight on its own. The per-beat term passes through one pipeline register and is then added into a 32-bit signed accumulator. The accumulator restarts on the first beat of each vector.

A one-cycle done pulse marks the point where the accumulator holds the complete result. Scaling by the two block-level floating-point factors is left to the consumer.

Top module: `nd_dot_unit`

## Requirements
- R1: In a beat, weight byte b (bits [8b+7:8b] of `in_wbytes`) holds weight b in bits [3:0] and weight b+32 in bits [7:4]. Weights are unsigned, 0 to 15, and are used as they are, with no recentring.
- R2: Activation j (0 to 63) is the signed 8-bit value at bits [8j+7:8j] of `in_act`. Weights 0..31 pair with activations 0..31 (low sub-block), and weights 32..63 pair with activations 32..63 (high sub-block).
- R3: The integer sum of each sub-block is exact for every combination of inputs, including all weights 15 with all activations -128.
- R4: The low sub-block sum is multiplied by `in_scale[3:0]` and the high sub-block sum by `in_scale[7:4]`. Both scales are unsigned.
- R5: For each sub-block, the product of its minimum and its activation sum is subtracted: `in_min[3:0]` × signed `in_psum[15:0]` for the low sub-block, and `in_min[7:4]` × signed `in_psum[31:16]` for the high one.
- R6: A beat with `in_first` high replaces the accumulator with that beat's term, discarding any earlier result.
- R7: Two clock edges after the edge that accepts a beat with `in_last` high, `out_done` is high for one cycle and `out_acc` holds the full vector result. `out_acc` keeps that value until a later beat is accepted.
- R8: A cycle with `in_valid` low has no effect on `out_acc` or `out_done`, whatever the other inputs carry.
- R9: While `rst` is high, `out_acc` is zero and `out_done` is low.
- R10: A new vector may start on the cycle right after the last beat of the previous one, and both results come out correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present this cycle |
| in_first | input | 1 | Beat is the first of a vector |
| in_last | input | 1 | Beat is the last of a vector |
| in_wbytes | input | 256 | 32 packed weight bytes |
| in_act | input | 512 | 64 signed activations |
| in_scale | input | 8 | Low/high sub-block scale fields |
| in_min | input | 8 | Low/high sub-block minimum fields |
| in_psum | input | 32 | Low/high sub-block signed activation sums |
| out_acc | output | 32 | Signed accumulated result |
| out_done | output | 1 | One-cycle pulse when the result is complete |

## Verification
A beat accepted at one rising edge has its term registered at that edge and accumulated at the next, so both the accumulator value and any done pulse it causes become visible two edges later. The bench's model computes each accepted beat's contribution at the moment it drives the beat, and queues the expected accumulator value and done flag tagged with the bench iteration two steps ahead. At every falling edge it pops whatever is due and compares it against both outputs. When nothing is due, it expects the accumulator to hold and done to stay low.

// File: rtl/nd_pkg.sv
package nd_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int ACT_W  = 8;
    localparam int PSUM_W = 16;
    localparam int ACC_W  = 32;
    localparam int LANES  = 16;

    localparam int PROD_W = NIB_W + ACT_W;   // unsigned nibble times signed byte
    localparam int PAIR_W = PROD_W + 1;      // two slice products per lane

    typedef logic signed [PROD_W-1:0] prod_t;

    // Registered per-beat contribution handed to the accumulator.
    typedef struct packed {
        logic                    valid;
        logic                    first;
        logic                    last;
        logic signed [ACC_W-1:0] term;
    } beat_t;

    // Width of a sub-block sum built from a given number of lane pairs.
    function automatic int sum_width(input int lanes);
        return PAIR_W + $clog2(lanes);
    endfunction

    // Pick the low or high nibble field of a packed byte.
    function automatic logic [NIB_W-1:0] nib_of(input logic [BYTE_W-1:0] b, input logic hi);
        return hi ? b[NIB_W +: NIB_W] : b[0 +: NIB_W];
    endfunction

    // Unsigned nibble times signed activation, exact in PROD_W bits.
    function automatic prod_t nib_mul(input logic [NIB_W-1:0] w, input logic [ACT_W-1:0] a);
        logic signed [PROD_W-1:0] wx;
        logic signed [PROD_W-1:0] ax;
        wx = $signed({{(PROD_W-NIB_W){1'b0}}, w});
        ax = $signed({{(PROD_W-ACT_W){a[ACT_W-1]}}, a});
        return wx * ax;
    endfunction

endpackage

// File: rtl/nd_lane_sum.sv
module nd_lane_sum
    import nd_pkg::*;
#(
    parameter int LANES = nd_pkg::LANES,
    parameter int SW    = nd_pkg::sum_width(LANES)
) (
    input  logic [2*LANES-1:0][NIB_W-1:0] wnib,
    input  logic [2*LANES-1:0][ACT_W-1:0] act,
    output logic signed [SW-1:0]          sum
);

    logic signed [PAIR_W-1:0] pair [LANES];

    // Lane l adds element l of the first slice to element l of the second.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        prod_t p_lo;
        prod_t p_hi;
        assign p_lo    = nib_mul(wnib[l], act[l]);
        assign p_hi    = nib_mul(wnib[l+LANES], act[l+LANES]);
        assign pair[l] = {p_lo[PROD_W-1], p_lo} + {p_hi[PROD_W-1], p_hi};
    end

    always_comb begin
        sum = '0;
        for (int l = 0; l < LANES; l++) begin
            sum = sum + {{(SW-PAIR_W){pair[l][PAIR_W-1]}}, pair[l]};
        end
    end

endmodule

// File: rtl/nd_chunk_term.sv
module nd_chunk_term
    import nd_pkg::*;
#(
    parameter int LANES   = nd_pkg::LANES,
    parameter int SUB_LEN = 2 * LANES
) (
    input  logic [SUB_LEN-1:0][BYTE_W-1:0]  wbytes,
    input  logic [2*SUB_LEN-1:0][ACT_W-1:0] act,
    input  logic [BYTE_W-1:0]               scale_b,
    input  logic [BYTE_W-1:0]               min_b,
    input  logic [1:0][PSUM_W-1:0]          psum,
    output logic signed [ACC_W-1:0]         term
);

    localparam int SW = sum_width(LANES);

    logic signed [ACC_W-1:0] part [2];

    // Half 0 takes low nibbles, half 1 high nibbles of the same bytes.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [SUB_LEN-1:0][NIB_W-1:0] wn;
        logic signed [SW-1:0]          s;
        logic signed [ACC_W-1:0]       s_x;
        logic signed [ACC_W-1:0]       p_x;
        logic signed [ACC_W-1:0]       sc_x;
        logic signed [ACC_W-1:0]       mn_x;

        always_comb begin
            for (int j = 0; j < SUB_LEN; j++) begin
                wn[j] = nib_of(wbytes[j], h == 1);
            end
        end

        nd_lane_sum #(
            .LANES (LANES),
            .SW    (SW)
        ) u_sum (
            .wnib (wn),
            .act  (act[h*SUB_LEN +: SUB_LEN]),
            .sum  (s)
        );

        assign s_x     = ACC_W'(s);
        assign p_x     = ACC_W'($signed(psum[h]));
        assign sc_x    = ACC_W'(nib_of(scale_b, h == 1));
        assign mn_x    = ACC_W'(nib_of(min_b, h == 1));
        assign part[h] = s_x * sc_x - mn_x * p_x;
    end

    assign term = part[0] + part[1];

endmodule

// File: rtl/nd_accum.sv
module nd_accum
    import nd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  beat_t                   beat,
    output logic signed [ACC_W-1:0] acc,
    output logic                    done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            done <= 1'b0;
        end else begin
            done <= beat.valid & beat.last;
            if (beat.valid) begin
                acc <= (beat.first ? '0 : acc) + beat.term;
            end
        end
    end

endmodule

// File: rtl/nd_dot_unit.sv
module nd_dot_unit
    import nd_pkg::*;
#(
    parameter int LANES = nd_pkg::LANES
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic                             in_first,
    input  logic                             in_last,
    input  logic [2*LANES*BYTE_W-1:0]        in_wbytes,
    input  logic [4*LANES*ACT_W-1:0]         in_act,
    input  logic [BYTE_W-1:0]                in_scale,
    input  logic [BYTE_W-1:0]                in_min,
    input  logic [2*PSUM_W-1:0]              in_psum,
    output logic signed [ACC_W-1:0]          out_acc,
    output logic                             out_done
);

    localparam int SUB_LEN = 2 * LANES;

    logic signed [ACC_W-1:0] term_c;
    beat_t                   beat_q;

    nd_chunk_term #(
        .LANES   (LANES),
        .SUB_LEN (SUB_LEN)
    ) u_term (
        .wbytes  (in_wbytes),
        .act     (in_act),
        .scale_b (in_scale),
        .min_b   (in_min),
        .psum    (in_psum),
        .term    (term_c)
    );

    // Pipeline register between the multiplier tree and the accumulator.
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= in_valid;
            beat_q.first <= in_first;
            beat_q.last  <= in_last;
            beat_q.term  <= term_c;
        end
    end

    nd_accum u_acc (
        .clk  (clk),
        .rst  (rst),
        .beat (beat_q),
        .acc  (out_acc),
        .done (out_done)
    );

endmodule

// File: rtl/nd_dot_checks.sv
module nd_dot_checks
    import nd_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_last,
    input logic signed [ACC_W-1:0] out_acc,
    input logic                    out_done
);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (out_acc == '0 && !out_done));

    p_done_follows_last_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> ##1 out_done);

    p_done_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(in_valid && in_last, 2));

    p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid, 2) |-> $stable(out_acc));

endmodule

bind nd_dot_unit nd_dot_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .out_acc  (out_acc),
    .out_done (out_done)
);

// File: tb/test_nd_dot_unit.sv
module test_nd_dot_unit;
    import nd_pkg::*;

    localparam int LN = 16;
    localparam int SL = 2 * LN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_first = 1'b0;
    logic in_last = 1'b0;
    logic [SL*8-1:0]   in_wbytes = '0;
    logic [2*SL*8-1:0] in_act = '0;
    logic [7:0]  in_scale = '0;
    logic [7:0]  in_min = '0;
    logic [31:0] in_psum = '0;
    logic signed [31:0] out_acc;
    logic out_done;

    always #5 clk = ~clk;

    nd_dot_unit #(.LANES(LN)) i_nd_dot_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_wbytes(in_wbytes), .in_act(in_act), .in_scale(in_scale), .in_min(in_min),
        .in_psum(in_psum), .out_acc(out_acc), .out_done(out_done)
    );

    typedef struct { int due; int acc; bit done; } exp_t;
    exp_t eq[$];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int ref_acc = 0;
    int exp_acc = 0;
    bit exp_done = 1'b0;
    bit fin = 1'b0;
    string cur_req = "R9";

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and compare both outputs against the model.
    task automatic step();
        @(negedge clk);
        cyc++;
        exp_done = 1'b0;
        if (eq.size() > 0 && eq[0].due == cyc) begin
            exp_acc  = eq[0].acc;
            exp_done = eq[0].done;
            void'(eq.pop_front());
        end
        check(out_acc == exp_acc, cur_req, "out_acc", out_acc, exp_acc);
        check(out_done == exp_done, cur_req, "out_done", int'(out_done), int'(exp_done));
    endtask

    task automatic set_psum();
        for (int h = 0; h < 2; h++) begin
            int p;
            p = 0;
            for (int j = 0; j < SL; j++) p += $signed(in_act[8*(h*SL+j) +: 8]);
            in_psum[16*h +: 16] = 16'(p);
        end
    endtask

    task automatic fill_rand();
        for (int j = 0; j < SL; j++) in_wbytes[8*j +: 8] = 8'($urandom);
        for (int j = 0; j < 2*SL; j++) in_act[8*j +: 8] = 8'($urandom);
        in_scale = 8'($urandom);
        in_min   = 8'($urandom);
        set_psum();
    endtask

    task automatic fill_uni(logic [7:0] wb, logic [7:0] alo, logic [7:0] ahi, logic [7:0] sc, logic [7:0] mn);
        for (int j = 0; j < SL; j++) in_wbytes[8*j +: 8] = wb;
        for (int j = 0; j < SL; j++) in_act[8*j +: 8] = alo;
        for (int j = SL; j < 2*SL; j++) in_act[8*j +: 8] = ahi;
        in_scale = sc;
        in_min   = mn;
        set_psum();
    endtask

    // Drive one cycle; the model computes the beat from the requirement text.
    task automatic apply(bit v, bit f, bit l);
        int term;
        term = 0;
        in_valid = v;
        in_first = f;
        in_last  = l;
        for (int h = 0; h < 2; h++) begin
            int s;
            int sc;
            int mn;
            s  = 0;
            sc = (h == 1) ? int'(in_scale[7:4]) : int'(in_scale[3:0]);
            mn = (h == 1) ? int'(in_min[7:4])   : int'(in_min[3:0]);
            for (int j = 0; j < SL; j++) begin
                int w;
                int a;
                w = (h == 1) ? int'(in_wbytes[8*j+4 +: 4]) : int'(in_wbytes[8*j +: 4]);
                a = $signed(in_act[8*(h*SL+j) +: 8]);
                s += w * a;
            end
            term += sc * s - mn * int'($signed(in_psum[16*h +: 16]));
        end
        if (v) begin
            ref_acc = f ? term : ref_acc + term;
            eq.push_back('{cyc + 2, ref_acc, l});
        end
        step();
    endtask

    task automatic run_vec(int nsb, int gap_pct);
        for (int k = 0; k < 4*nsb; k++) begin
            while (int'($urandom % 100) < gap_pct) begin
                fill_rand();
                apply(1'b0, 1'($urandom), 1'($urandom));
            end
            fill_rand();
            apply(1'b1, k == 0, k == 4*nsb - 1);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_acc == 0 && !out_done, "R9", "reset state", out_acc, 0);
        rst = 1'b0;
        step();

        // R1 / R4: layout and per-half scale, 3*32 + 5*(2*3*32)
        cur_req = "R1";
        fill_uni(8'h21, 8'd1, 8'd3, 8'h53, 8'h00);
        apply(1'b1, 1'b1, 1'b1);
        apply(1'b0, 1'b0, 1'b0);
        check(out_done && out_acc == 1056, "R4", "layout+scale", out_acc, 1056);

        // R5: minimum correction 1*32 + 2*96 removed
        cur_req = "R5";
        fill_uni(8'h21, 8'd1, 8'd3, 8'h53, 8'h21);
        apply(1'b1, 1'b1, 1'b1);
        apply(1'b0, 1'b0, 1'b0);
        check(out_done && out_acc == 832, "R5", "min correction", out_acc, 832);

        // R2: signed activations, -32 + 2*(-128)*32
        cur_req = "R2";
        fill_uni(8'h21, 8'hFF, 8'h80, 8'h11, 8'h00);
        apply(1'b1, 1'b1, 1'b1);
        apply(1'b0, 1'b0, 1'b0);
        check(out_done && out_acc == -8224, "R2", "signed acts", out_acc, -8224);

        // R3: extreme magnitudes over one super-block
        cur_req = "R3";
        fill_uni(8'hFF, 8'h80, 8'h80, 8'hFF, 8'hFF);
        for (int k = 0; k < 4; k++) apply(1'b1, k == 0, k == 3);
        apply(1'b0, 1'b0, 1'b0);
        check(out_done && out_acc == -6881280, "R3", "extreme sum", out_acc, -6881280);

        // R7 / R8: result held, done low, through idle cycles with garbage
        cur_req = "R8";
        for (int k = 0; k < 3; k++) begin
            fill_rand();
            apply(1'b0, 1'b1, 1'b1);
        end
        check(!out_done && out_acc == -6881280, "R7", "hold after done", out_acc, -6881280);

        // R6: new vectors restart the accumulator, with idle gaps inside
        cur_req = "R6";
        for (int n = 0; n < 4; n++) run_vec(1 + n % 3, 30);
        apply(1'b0, 1'b0, 1'b0);

        // R10: vectors back to back with no idle cycle
        cur_req = "R10";
        for (int n = 0; n < 5; n++) run_vec(1 + n % 2, 0);
        for (int k = 0; k < 3; k++) apply(1'b0, 1'b0, 1'b0);

        fin = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL R7 watchdog: actual no finish expected finish");
            summary();
            $finish;
        end
    end

endmodule